// File: doc/BRIEF.md
# Store-Wait Memory Dependence Predictor

This block decides, for every load that is ready to issue, whether it may go ahead of older stores whose addresses are still unknown. It keeps one bit per table entry, indexed by the load's program counter. A cleared bit lets the load issue speculatively. A set bit makes the load hold back until every older store has completed. The pipeline reports a load PC whenever a speculatively issued load turned out to alias an older store. That report sets the load's bit, so later runs of the same load instruction behave conservatively.

Because conservative behaviour costs performance, the table is wiped at regular intervals by a free-running timer. The interval is a programmable number of cycles, and zero disables the wipe. Loads that no longer conflict then get to speculate again. Detecting the alias and squashing the pipeline are done elsewhere.

Top module: `storewait_predictor`

## Requirements
- R1: A synchronous reset (active high) clears every table entry and drops `issue_vld` in the next cycle.
- R2: A query to an entry that is not marked returns `issue_ok`=1, whatever the state of `q_older_done`.
- R3: A violation report sets the entry selected by PC bits [11:2]. PC bits [1:0] and bits [31:12] do not take part, so PCs that differ only in those bits share an entry.
- R4: A query to a marked entry returns `issue_ok`=0 when `q_older_done`=0, and returns 1 when `q_older_done`=1.
- R5: `issue_vld` and `issue_ok` appear exactly one cycle after the query is presented. `issue_vld` is 0 in any cycle that follows a cycle with no query.
- R6: With `clr_interval`=N>0, written while the timer is idle, every entry is cleared on the Nth clock edge, and again every N edges after that. With N=0 no clear ever happens and the timer is held at zero.
- R7: When a clear and a violation report fall on the same edge, the clear wins and the reported entry stays unmarked.
- R8: A query in the same cycle as a violation report or a clear returns the entry's value from before that edge.
- R9: A violation report changes only the one entry it selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| q_valid | input | 1 | A load issue query is presented |
| q_pc | input | 32 | PC of the querying load |
| q_older_done | input | 1 | All older stores have completed |
| viol_valid | input | 1 | An ordering violation is reported |
| viol_pc | input | 32 | PC of the load that violated |
| clr_interval | input | 20 | Cycles between global clears; 0 disables clearing |
| issue_vld | output | 1 | The result below belongs to the previous cycle's query |
| issue_ok | output | 1 | The load may issue |

## Verification
The hardest case to reach from the ports is a clear edge that coincides with both a violation report and a query. The timer phase is not visible at the ports. To pin the phase down, the stimulus holds the interval at zero, which keeps the timer at zero. It then writes a small interval at a known edge and counts edges to place the report and the query exactly on the clear edge. The queries after that edge show that the wipe removed the older marks and also overrode the new one.

// File: rtl/storewait_pkg.sv
package storewait_pkg;
  localparam int unsigned SW_PC_W  = 32;
  localparam int unsigned SW_ALIGN = 2;
  localparam int unsigned SW_IDX_W = 10;
  localparam int unsigned SW_CNT_W = 20;

  typedef struct packed {
    logic vld;
    logic ok;
  } sw_result_t;
endpackage

// File: rtl/sw_clear_timer.sv
module sw_clear_timer #(
  parameter int unsigned CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] interval,
  output logic             clr
);
  logic [CNT_W-1:0] cnt;
  logic             enabled;
  logic [CNT_W-1:0] last;

  assign enabled = (interval != '0);
  assign last    = interval - 1'b1;
  assign clr     = enabled && (cnt >= last);

  always_ff @(posedge clk) begin
    if (rst || !enabled || clr) cnt <= '0;
    else                        cnt <= cnt + 1'b1;
  end

  // R6
  no_clear_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    (interval == '0) |-> !clr);
endmodule

// File: rtl/sw_bit_table.sv
module sw_bit_table #(
  parameter int unsigned IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             set,
  input  logic [IDX_W-1:0] set_idx,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_bit
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0] marks;
  logic             set_q;
  logic             clr_q;
  logic [IDX_W-1:0] set_idx_q;
  logic             started;

  always_ff @(posedge clk) begin
    if (rst || clr) marks <= '0;
    else if (set)   marks[set_idx] <= 1'b1;
  end

  // Read before write: the read returns the value held before this edge.
  always_ff @(posedge clk) begin
    if (rst) rd_bit <= 1'b0;
    else     rd_bit <= marks[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      set_q     <= 1'b0;
      clr_q     <= 1'b0;
      set_idx_q <= '0;
      started   <= 1'b0;
    end else begin
      set_q     <= set;
      clr_q     <= clr;
      set_idx_q <= set_idx;
      started   <= 1'b1;
    end
  end

  // R3
  set_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (started && set_q && !clr_q) |-> marks[set_idx_q]);

  // R6
  clear_all_chk: assert property (@(posedge clk) disable iff (rst)
    (started && clr_q) |-> ($countones(marks) == 0));
endmodule

// File: rtl/storewait_predictor.sv
module storewait_predictor
  import storewait_pkg::*;
#(
  parameter int unsigned PC_W  = SW_PC_W,
  parameter int unsigned ALIGN = SW_ALIGN,
  parameter int unsigned IDX_W = SW_IDX_W,
  parameter int unsigned CNT_W = SW_CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             q_valid,
  input  logic [PC_W-1:0]  q_pc,
  input  logic             q_older_done,
  input  logic             viol_valid,
  input  logic [PC_W-1:0]  viol_pc,
  input  logic [CNT_W-1:0] clr_interval,
  output logic             issue_vld,
  output logic             issue_ok
);
  localparam int unsigned IDX_LO = ALIGN;
  localparam int unsigned IDX_HI = ALIGN + IDX_W - 1;

  logic [IDX_W-1:0] q_idx;
  logic [IDX_W-1:0] v_idx;
  logic             clr;
  logic             mark;
  logic             done_q;
  sw_result_t       res;

  assign q_idx = q_pc[IDX_HI:IDX_LO];
  assign v_idx = viol_pc[IDX_HI:IDX_LO];

  logic unused_pc_bits;
  assign unused_pc_bits = ^{q_pc[PC_W-1:IDX_HI+1], q_pc[IDX_LO-1:0],
                            viol_pc[PC_W-1:IDX_HI+1], viol_pc[IDX_LO-1:0]};

  sw_clear_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .interval (clr_interval),
    .clr      (clr)
  );

  sw_bit_table #(.IDX_W(IDX_W)) u_table (
    .clk     (clk),
    .rst     (rst),
    .clr     (clr),
    .set     (viol_valid),
    .set_idx (v_idx),
    .rd_idx  (q_idx),
    .rd_bit  (mark)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res.vld <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      res.vld <= q_valid;
      done_q  <= q_older_done;
    end
  end

  assign res.ok    = res.vld && (!mark || done_q);
  assign issue_vld = res.vld;
  assign issue_ok  = res.ok;

  // R5
  result_timing_chk: assert property (@(posedge clk) disable iff (rst)
    !q_valid |=> !issue_vld);

  // R4
  older_done_chk: assert property (@(posedge clk) disable iff (rst)
    (q_valid && q_older_done) |=> issue_ok);

  // R5
  ok_needs_vld_chk: assert property (@(posedge clk) disable iff (rst)
    issue_ok |-> issue_vld);
endmodule

// File: tb/sim_storewait_predictor.sv
module sim_storewait_predictor;
  logic        clk = 1'b0;
  logic        rst;
  logic        q_valid;
  logic [31:0] q_pc;
  logic        q_older_done;
  logic        viol_valid;
  logic [31:0] viol_pc;
  logic [19:0] clr_interval;
  logic        issue_vld;
  logic        issue_ok;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  storewait_predictor u0 (
    .clk(clk), .rst(rst), .q_valid(q_valid), .q_pc(q_pc),
    .q_older_done(q_older_done), .viol_valid(viol_valid), .viol_pc(viol_pc),
    .clr_interval(clr_interval), .issue_vld(issue_vld), .issue_ok(issue_ok)
  );

  // {viol, viol_pc, query, q_pc, older_done, expected ok}
  localparam int NV = 10;
  localparam logic [67:0] VEC [NV] = '{
    {1'b0, 32'h0000_0000, 1'b1, 32'h0000_0014, 1'b0, 1'b1}, // R2 fresh entry 5
    {1'b1, 32'h0000_0014, 1'b1, 32'h0000_0014, 1'b0, 1'b1}, // R8 same-cycle old value
    {1'b0, 32'h0000_0000, 1'b1, 32'h0000_0014, 1'b0, 1'b0}, // R3 R4 marked, wait
    {1'b0, 32'h0000_0000, 1'b1, 32'h0000_0014, 1'b1, 1'b1}, // R4 older done
    {1'b0, 32'h0000_0000, 1'b1, 32'h0000_0018, 1'b0, 1'b1}, // R9 entry 6 untouched
    {1'b1, 32'h0000_0018, 1'b0, 32'h0000_0000, 1'b0, 1'b0}, // R5 no query
    {1'b0, 32'h0000_0000, 1'b1, 32'h0000_0018, 1'b0, 1'b0}, // R3 entry 6 marked
    {1'b0, 32'h0000_0000, 1'b1, 32'h0000_1014, 1'b0, 1'b0}, // R3 upper bits alias
    {1'b0, 32'h0000_0000, 1'b1, 32'h0000_0017, 1'b0, 1'b0}, // R3 low bits ignored
    {1'b0, 32'h0000_0000, 1'b1, 32'h0000_001C, 1'b0, 1'b1}  // R9 entry 7 untouched
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [31:0] vp, input logic q,
                       input logic [31:0] qp, input logic d);
    viol_valid = v; viol_pc = vp; q_valid = q; q_pc = qp; q_older_done = d;
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    rst = 1'b1;
    clr_interval = '0;
    drive(1'b0, '0, 1'b0, '0, 1'b0);
    step; step;
    check("R1 vld after reset", issue_vld, 1'b0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][67], VEC[i][66:35], VEC[i][34], VEC[i][33:2], VEC[i][1]);
      step;
      check("R5 vld", issue_vld, VEC[i][34]);
      if (VEC[i][34]) check($sformatf("vector %0d ok (R2/R3/R4/R8/R9)", i), issue_ok, VEC[i][0]);
    end

    // R6 R7 R8: interval 4 written with timer idle; clear on the 4th edge
    drive(1'b0, '0, 1'b0, '0, 1'b0);
    clr_interval = 20'd4;
    step; step; step;
    drive(1'b1, 32'h0000_0024, 1'b1, 32'h0000_0014, 1'b0);
    step;
    check("R8 query on clear edge", issue_ok, 1'b0);
    clr_interval = '0;
    drive(1'b0, '0, 1'b1, 32'h0000_0014, 1'b0);
    step;
    check("R6 entry 5 cleared", issue_ok, 1'b1);
    drive(1'b0, '0, 1'b1, 32'h0000_0018, 1'b0);
    step;
    check("R6 entry 6 cleared", issue_ok, 1'b1);
    drive(1'b0, '0, 1'b1, 32'h0000_0024, 1'b0);
    step;
    check("R7 clear beats set", issue_ok, 1'b1);

    // R6: interval 0 never clears
    drive(1'b1, 32'h0000_0030, 1'b0, '0, 1'b0);
    step;
    drive(1'b0, '0, 1'b0, '0, 1'b0);
    for (int k = 0; k < 20; k++) step;
    drive(1'b0, '0, 1'b1, 32'h0000_0030, 1'b0);
    step;
    check("R6 no clear when off", issue_ok, 1'b0);

    // R1: reset wipes entries
    drive(1'b0, '0, 1'b0, '0, 1'b0);
    rst = 1'b1;
    step;
    check("R1 vld in reset", issue_vld, 1'b0);
    rst = 1'b0;
    drive(1'b0, '0, 1'b1, 32'h0000_0030, 1'b0);
    step;
    check("R1 entry cleared by reset", issue_ok, 1'b1);

    drive(1'b0, '0, 1'b0, '0, 1'b0);
    step;
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule